// File: doc/BRIEF.md
# Classifier Rule Table Access Engine

This block gives a host processor register-level access to a ternary rule table used for packet classification. Each rule slot holds eight 32-bit data words and eight 32-bit mask words; a mask bit of 1 means the matching data bit is compared. Two side memories are kept per slot as well: an action/policer record and a rate-meter record. The host fills staging registers and then starts a write. It can also start a read, which fills the staging registers from the addressed slot. One control word carries the operation, the target memory, the slot address, a self-clearing start flag, a hit flag and a table-clear flag.

The search operation is driven by the host. It walks the rule table from slot 1 upward and stops on each slot whose validity bits are set. It loads that rule into staging and raises the hit flag. It moves on only after the host has read the last data word. The start flag stays high for the whole walk. Slot 0 is reserved and is never visited. A rule is removed by reading it, clearing its validity bits and writing it back.

Top module: `tcam_acc_top`

## Requirements
- R1: After reset the control word (index 0) reads 0 and every staging data word (indices 8..15) and mask word (indices 16..23) reads 0.
- R2: The control word has these fields: op in bits [1:0] (1 read, 2 write, 3 search), memory in bits [3:2] (0 rule table, 1 action, 2 meter), start in bit 4, hit in bit 5, clear in bit 6 and slot address in bits [15:8]. A rule-table write followed by a read of the same slot returns all data and mask words into staging.
- R3: For a read or write, the start bit reads 1 for exactly OP_LAT (default 2) cycles after the control write and then 0. The staging registers hold the result once it reads 0.
- R4: A control write while an operation is in progress is ignored. The op, memory and address fields keep their values and no second operation runs.
- R5: The action memory stores staging data words 0..2 and the meter memory stores data word 0. Writing either leaves the rule table unchanged. Reading either replaces only those staging words.
- R6: A search never reports slot 0, even when slot 0 holds a valid rule.
- R7: A search reports valid slots in ascending order. On each one the hit bit is 1, the address field shows the slot and staging holds that slot's data and mask.
- R8: While the hit bit is 1, the engine holds the slot and the staging contents until data word 7 (index 15) is read. Reads of other words do not advance it.
- R9: The start bit stays 1 from the start of a search until the last slot has been examined. The search then ends with start 0, hit 0 and address 255.
- R10: A slot whose data word 0 has bits [1:0] equal to 0 is not valid and is skipped by the search.
- R11: Setting the clear bit (with start 0) zeroes every slot of the rule table. The clear bit reads 1 while the table is cleared and returns to 0 when it is done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (used to detect the last-word read during a search) |
| reg_idx | input | 5 | Register index: 0 control, 8..15 data words, 16..23 mask words |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_idx, combinational |

## Verification
A wrong sequencer state shows up on the next control read. The start bit stays high or drops early, or the address field shows a slot that was never reached. Both are visible at most OP_LAT cycles after a read or write. A search that skips a slot, returns slot 0 or moves on early puts the wrong address or the wrong staged words in front of the host at the very next hit. A clear that misses slots leaves nonzero words in a later read-back, and a later search reports hits where none should appear.

// File: rtl/tcam_acc_pkg.sv
package tcam_acc_pkg;

    localparam int N_WORDS    = 8;
    localparam int WORD_W     = 32;
    localparam int WSEL_W     = $clog2(N_WORDS);
    localparam int REG_IDX_W  = WSEL_W + 2;
    localparam int ACT_WORDS  = 3;

    // control word bit positions
    localparam int CB_OP_LO   = 0;
    localparam int CB_RAM_LO  = 2;
    localparam int CB_START   = 4;
    localparam int CB_HIT     = 5;
    localparam int CB_CLR     = 6;
    localparam int CB_ADDR_LO = 8;

    // register regions selected by the upper index bits
    localparam logic [1:0] RGN_CTRL = 2'b00;
    localparam logic [1:0] RGN_DATA = 2'b01;
    localparam logic [1:0] RGN_MASK = 2'b10;

    typedef enum logic [1:0] {
        OP_NONE   = 2'd0,
        OP_READ   = 2'd1,
        OP_WRITE  = 2'd2,
        OP_SEARCH = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RAM_TBL  = 2'd0,
        RAM_ACT  = 2'd1,
        RAM_MTR  = 2'd2,
        RAM_NONE = 2'd3
    } ram_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RW,
        ST_SCAN,
        ST_HOLD,
        ST_CLR
    } st_e;

    typedef struct packed {
        logic we_tbl;
        logic we_act;
        logic we_mtr;
        logic ld_tbl;
        logic ld_act;
        logic ld_mtr;
        logic clr;
    } seq_cmd_t;

    function automatic logic rule_valid(input logic [WORD_W-1:0] w0);
        return |w0[1:0];
    endfunction

endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
    parameter int W     = 32,
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/tcam_acc_seq.sv
module tcam_acc_seq
    import tcam_acc_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int OP_LAT  = 2,
    localparam int AW     = $clog2(ENTRIES),
    localparam int CW     = $clog2(OP_LAT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  op_e           op_in,
    input  ram_e          ram_in,
    input  logic [AW-1:0] addr_in,
    input  logic          start_in,
    input  logic          clr_in,
    input  logic          hit_ack,
    input  logic          cur_valid,
    output logic          busy,
    output logic          hit,
    output logic          clearing,
    output op_e           op_q,
    output ram_e          ram_q,
    output logic [AW-1:0] addr_q,
    output seq_cmd_t      cmd
);

    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

    st_e           st;
    logic [CW-1:0] cnt;
    logic          rw_fire;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            op_q   <= OP_NONE;
            ram_q  <= RAM_TBL;
            addr_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (ctrl_wr) begin
                    op_q   <= op_in;
                    ram_q  <= ram_in;
                    addr_q <= addr_in;
                    if (start_in) begin
                        if (op_in == OP_SEARCH) begin
                            st     <= ST_SCAN;
                            addr_q <= AW'(1);
                        end else begin
                            st  <= ST_RW;
                            cnt <= CW'(OP_LAT - 1);
                        end
                    end else if (clr_in) begin
                        st     <= ST_CLR;
                        addr_q <= '0;
                    end
                end
                ST_RW: begin
                    if (cnt == '0) st <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
                ST_SCAN: begin
                    if (cur_valid)           st <= ST_HOLD;
                    else if (addr_q == LAST) st <= ST_IDLE;
                    else                     addr_q <= addr_q + 1'b1;
                end
                ST_HOLD: if (hit_ack) begin
                    if (addr_q == LAST) st <= ST_IDLE;
                    else begin
                        st     <= ST_SCAN;
                        addr_q <= addr_q + 1'b1;
                    end
                end
                ST_CLR: begin
                    if (addr_q == LAST) st <= ST_IDLE;
                    else                addr_q <= addr_q + 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign rw_fire  = (st == ST_RW) && (cnt == '0);
    assign busy     = (st == ST_RW) || (st == ST_SCAN) || (st == ST_HOLD);
    assign hit      = (st == ST_HOLD);
    assign clearing = (st == ST_CLR);

    always_comb begin
        cmd        = '0;
        cmd.clr    = (st == ST_CLR);
        cmd.we_tbl = (rw_fire && op_q == OP_WRITE && ram_q == RAM_TBL) || (st == ST_CLR);
        cmd.we_act = rw_fire && op_q == OP_WRITE && ram_q == RAM_ACT;
        cmd.we_mtr = rw_fire && op_q == OP_WRITE && ram_q == RAM_MTR;
        cmd.ld_tbl = (rw_fire && op_q == OP_READ && ram_q == RAM_TBL) ||
                     (st == ST_SCAN && cur_valid);
        cmd.ld_act = rw_fire && op_q == OP_READ && ram_q == RAM_ACT;
        cmd.ld_mtr = rw_fire && op_q == OP_READ && ram_q == RAM_MTR;
    end

    AST_BUSY_IGNORES_CTRL: assert property (@(posedge clk) disable iff (rst)
        (busy && ctrl_wr) |=> ($stable(op_q) && $stable(ram_q))); // R4

    AST_SEARCH_FROM_ONE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && ctrl_wr && start_in && op_in == OP_SEARCH)
        |=> (st == ST_SCAN && addr_q == AW'(1))); // R6

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !hit_ack) |=> (st == ST_HOLD && $stable(addr_q))); // R8

    AST_SCAN_STEPS: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SCAN && !cur_valid && addr_q != LAST)
        |=> (busy && addr_q == $past(addr_q) + 1'b1)); // R9

endmodule

// File: rtl/tcam_acc_top.sv
module tcam_acc_top
    import tcam_acc_pkg::*;
#(
    parameter int ENTRIES = 256,
    parameter int OP_LAT  = 2,
    localparam int AW     = $clog2(ENTRIES),
    localparam int DW     = N_WORDS * WORD_W,
    localparam int ACT_W  = ACT_WORDS * WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_IDX_W-1:0] reg_idx,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata
);

    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

    logic [N_WORDS-1:0][WORD_W-1:0] stg_d, stg_m;
    logic [1:0]        rgn;
    logic [WSEL_W-1:0] wsel;
    logic              ctrl_wr, hit_ack, cur_valid;
    logic              busy, hit, clearing;
    op_e               op_q;
    ram_e              ram_q;
    logic [AW-1:0]     addr_q;
    seq_cmd_t          cmd;
    logic [2*DW-1:0]   tbl_wd, tbl_rd;
    logic [ACT_W-1:0]  act_rd;
    logic [WORD_W-1:0] mtr_rd;
    logic              unused_bits;

    assign rgn         = reg_idx[REG_IDX_W-1 -: 2];
    assign wsel        = reg_idx[WSEL_W-1:0];
    assign ctrl_wr     = reg_wr && reg_idx == '0;
    assign hit_ack     = reg_rd && rgn == RGN_DATA && wsel == WSEL_W'(N_WORDS - 1);
    assign unused_bits = ^{reg_wdata[WORD_W-1:CB_ADDR_LO+AW], reg_wdata[CB_ADDR_LO-1], tbl_rd[DW-1:WORD_W]};

    tcam_acc_seq #(.ENTRIES(ENTRIES), .OP_LAT(OP_LAT)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .op_in    (op_e'(reg_wdata[CB_OP_LO +: 2])),
        .ram_in   (ram_e'(reg_wdata[CB_RAM_LO +: 2])),
        .addr_in  (reg_wdata[CB_ADDR_LO +: AW]),
        .start_in (reg_wdata[CB_START]),
        .clr_in   (reg_wdata[CB_CLR]),
        .hit_ack  (hit_ack),
        .cur_valid(cur_valid),
        .busy     (busy),
        .hit      (hit),
        .clearing (clearing),
        .op_q     (op_q),
        .ram_q    (ram_q),
        .addr_q   (addr_q),
        .cmd      (cmd)
    );

    assign tbl_wd    = cmd.clr ? '0 : {stg_m, stg_d};
    assign cur_valid = rule_valid(tbl_rd[WORD_W-1:0]);

    tcam_entry_store #(.W(2*DW), .DEPTH(ENTRIES)) u_tbl (
        .clk(clk), .we(cmd.we_tbl), .addr(addr_q), .wdata(tbl_wd), .rdata(tbl_rd)
    );

    tcam_entry_store #(.W(ACT_W), .DEPTH(ENTRIES)) u_act (
        .clk(clk), .we(cmd.we_act), .addr(addr_q),
        .wdata(stg_d[ACT_WORDS-1:0]), .rdata(act_rd)
    );

    tcam_entry_store #(.W(WORD_W), .DEPTH(ENTRIES)) u_mtr (
        .clk(clk), .we(cmd.we_mtr), .addr(addr_q), .wdata(stg_d[0]), .rdata(mtr_rd)
    );

    // staging: host writes first, engine loads take precedence
    always_ff @(posedge clk) begin
        if (rst) begin
            stg_d <= '0;
            stg_m <= '0;
        end else begin
            if (reg_wr && rgn == RGN_DATA) stg_d[wsel] <= reg_wdata;
            if (reg_wr && rgn == RGN_MASK) stg_m[wsel] <= reg_wdata;
            if (cmd.ld_tbl) begin
                stg_d <= tbl_rd[DW-1:0];
                stg_m <= tbl_rd[2*DW-1:DW];
            end
            if (cmd.ld_act) stg_d[ACT_WORDS-1:0] <= act_rd;
            if (cmd.ld_mtr) stg_d[0] <= mtr_rd;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (rgn)
            RGN_CTRL: if (wsel == '0) begin
                reg_rdata[CB_OP_LO +: 2]    = op_q;
                reg_rdata[CB_RAM_LO +: 2]   = ram_q;
                reg_rdata[CB_START]         = busy;
                reg_rdata[CB_HIT]           = hit;
                reg_rdata[CB_CLR]           = clearing;
                reg_rdata[CB_ADDR_LO +: AW] = addr_q;
            end
            RGN_DATA: reg_rdata = stg_d[wsel];
            RGN_MASK: reg_rdata = stg_m[wsel];
            default:  reg_rdata = '0;
        endcase
    end

    AST_STAGE_HELD: assert property (@(posedge clk) disable iff (rst)
        (hit && !reg_wr && !hit_ack) |=> ($stable(stg_d) && $stable(stg_m))); // R8

    AST_CLEAR_SPAN: assert property (@(posedge clk) disable iff (rst)
        $fell(clearing) |-> (addr_q == LAST && !busy)); // R11

endmodule

// File: tb/tcam_acc_top_test.sv
`timescale 1ns/1ps
module tcam_acc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [4:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #2.5 clk = ~clk;

    tcam_acc_top uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [31:0] got_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];

    localparam int CTRL = 0;
    function automatic int DI(int k); return 8 + k;  endfunction
    function automatic int MI(int k); return 16 + k; endfunction

    function automatic logic [31:0] ctl(int op, int ram, int a, bit st, bit cl);
        return (32'(op) & 32'd3) | ((32'(ram) & 32'd3) << 2) | (32'(st) << 4) |
               (32'(cl) << 6) | ((32'(a) & 32'hFF) << 8);
    endfunction

    function automatic logic [31:0] dval(int e, int k);
        logic [31:0] v;
        v = {8'(e), 8'hC3, 8'(k), 8'h10};
        if (k == 0) v[0] = 1'b1;
        return v;
    endfunction

    function automatic logic [31:0] mval(int e, int k);
        return {8'h0F, 8'(k), 8'(e), 8'h77};
    endfunction

    // scoreboard producer
    task automatic post(input logic [31:0] g, input logic [31:0] e, input string t);
        got_q.push_back(g);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    // scoreboard consumer
    initial forever begin
        @(negedge clk);
        while (got_q.size() > 0) begin
            logic [31:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (g !== e) begin
                n_bad++;
                $display("FAIL %s: got %h expected %h", t, g, e);
            end
        end
    end

    task automatic wr(input int idx, input logic [31:0] v);
        reg_idx = 5'(idx); reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] v);
        reg_idx = 5'(idx); reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic chk(input int idx, input logic [31:0] e, input string t);
        logic [31:0] v;
        rd(idx, v);
        post(v, e, t);
    endtask

    // poll the control word until bit b drops, or (stop_on_hit) hit rises
    task automatic poll(input int b, input bit stop_on_hit, output logic [31:0] v);
        for (int i = 0; i < 5000; i++) begin
            rd(CTRL, v);
            if (!v[b] || (stop_on_hit && v[5])) return;
        end
        post(32'hDEAD, 32'h0, "poll timeout");
    endtask

    task automatic run_op(input int op, input int ram, input int a);
        logic [31:0] v;
        wr(CTRL, ctl(op, ram, a, 1, 0));
        poll(4, 0, v);
    endtask

    task automatic put_entry(input int e, input bit valid);
        for (int k = 0; k < 8; k++) begin
            logic [31:0] d;
            d = dval(e, k);
            if (k == 0 && !valid) d[1:0] = 2'b00;
            wr(DI(k), d);
            wr(MI(k), mval(e, k));
        end
        run_op(2, 0, e);
    endtask

    initial begin
        logic [31:0] v;
        int hits[3] = '{5, 200, 255};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1
        chk(CTRL, 32'h0, "R1 ctrl after reset");
        chk(DI(0), 32'h0, "R1 data0 after reset");
        chk(MI(3), 32'h0, "R1 mask3 after reset");

        // R11: clear flag visible while the table is cleared
        wr(CTRL, ctl(0, 0, 0, 0, 1));
        rd(CTRL, v);
        post(32'(v[6:4]), 32'b100, "R11 clear flag set");
        poll(6, 0, v);
        post(32'(v[6]), 32'h0, "R11 clear flag drops");

        // R3: exact start-bit duration on a write to slot 5
        for (int k = 0; k < 8; k++) begin
            wr(DI(k), dval(5, k));
            wr(MI(k), mval(5, k));
        end
        wr(CTRL, ctl(2, 0, 5, 1, 0));
        rd(CTRL, v); post(32'(v[4]), 32'h1, "R3 start bit cycle 1");
        rd(CTRL, v); post(32'(v[4]), 32'h1, "R3 start bit cycle 2");
        rd(CTRL, v); post(32'(v[4]), 32'h0, "R3 start bit cleared");

        put_entry(0, 1);
        put_entry(7, 0);
        put_entry(9, 1);
        put_entry(200, 1);
        put_entry(255, 1);

        // R2: round trip of slot 5 after trashing staging
        for (int k = 0; k < 8; k++) begin
            wr(DI(k), 32'hFFFF_FFFF);
            wr(MI(k), 32'hFFFF_FFFF);
        end
        run_op(1, 0, 5);
        chk(DI(0), dval(5, 0), "R2 read data0");
        chk(DI(7), dval(5, 7), "R2 read data7");
        chk(MI(2), mval(5, 2), "R2 read mask2");
        chk(MI(7), mval(5, 7), "R2 read mask7");

        // R4: second request during a read is dropped
        wr(CTRL, ctl(1, 0, 9, 1, 0));
        wr(CTRL, ctl(2, 0, 3, 1, 0));
        poll(4, 0, v);
        post(v & 32'hFF0F, ctl(1, 0, 9, 0, 0), "R4 ctrl fields kept");
        chk(DI(1), dval(9, 1), "R4 first read result");
        run_op(1, 0, 3);
        chk(DI(0), 32'h0, "R4 ignored write left slot 3 empty");

        // R5: action and meter memories
        for (int k = 0; k < 3; k++) wr(DI(k), 32'hACE0_0000 + 32'(k));
        run_op(2, 1, 5);
        run_op(1, 0, 5);
        chk(DI(0), dval(5, 0), "R5 table untouched by action write");
        run_op(1, 1, 5);
        chk(DI(2), 32'hACE0_0002, "R5 action word2");
        chk(DI(3), dval(5, 3), "R5 word3 not loaded by action read");
        wr(DI(0), 32'h0000_BEEF);
        run_op(2, 2, 5);
        wr(DI(0), 32'h0);
        run_op(1, 2, 5);
        chk(DI(0), 32'h0000_BEEF, "R5 meter word0");
        chk(DI(1), 32'hACE0_0001, "R5 meter read leaves word1");

        // R10: delete slot 9 by clearing its validity bits
        run_op(1, 0, 9);
        rd(DI(0), v);
        wr(DI(0), v & ~32'h3);
        run_op(2, 0, 9);

        // R6 R7 R8 R9 R10: search walk
        wr(CTRL, ctl(3, 0, 0, 1, 0));
        foreach (hits[i]) begin
            poll(4, 1, v);
            post(32'(v[5:4]), 32'b11, "R7 hit with start held");
            post(32'(v[15:8]), 32'(hits[i]), "R6 R7 R10 hit slot order");
            chk(DI(1), dval(hits[i], 1), "R7 staged data");
            chk(MI(4), mval(hits[i], 4), "R7 staged mask");
            rd(CTRL, v);
            post(v[15:0] & 16'hFF30, (32'(hits[i]) << 8) | 32'h30, "R8 held before last word");
            rd(DI(7), v);
        end
        poll(4, 1, v);
        post(v & 32'hFF30, 32'hFF00, "R9 search ends at last slot");

        // R11: clear wipes rules
        wr(CTRL, ctl(0, 0, 0, 0, 1));
        poll(6, 0, v);
        run_op(1, 0, 200);
        chk(DI(0), 32'h0, "R11 slot 200 data zero");
        chk(MI(5), 32'h0, "R11 slot 200 mask zero");
        wr(CTRL, ctl(3, 0, 0, 1, 0));
        poll(4, 1, v);
        post(v & 32'hFF30, 32'hFF00, "R11 search finds nothing");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule